// File: doc/BRIEF.md
# x86 Vector Prefix Classifier

The classifier sits at the head of an x86 decode pipeline. It takes in the first bytes of an instruction, one byte per accepted handshake. From them it works out whether the instruction starts with a REX prefix, a two-byte VEX prefix, a three-byte VEX prefix, a four-byte EVEX prefix, or no such prefix. The hard part is that the vector lead bytes are ambiguous. Outside 64-bit mode they are also legacy opcodes (LES, LDS, BOUND). Which reading applies depends on the processor mode and on the top two bits of the byte that follows.

For each instruction the block reports a result:

- the prefix class;
- the prefix length;
- how many bytes it took from the stream;
- the register-extension bits, with the stored-inverted fields already complemented;
- an invalid-opcode flag for vector prefixes met in real or virtual-8086 mode.

It then holds that result and takes no more bytes until the consumer acknowledges it.

Top module: `vpc_top`

## Requirements
- R1: Lead byte 0xC5 followed by a qualifying second byte gives class VEX2 (code 2), length 2, 2 bytes used.
- R2: Lead byte 0xC4 followed by a qualifying second byte gives class VEX3 (code 3), length 3, 3 bytes used.
- R3: Lead byte 0x62 followed by a qualifying second byte gives class EVEX (code 4), length 4, 4 bytes used.
- R4: Outside 64-bit mode, the second byte qualifies only when its bits [7:6] are 11. Otherwise the result is class NONE (code 0), length 0, 2 bytes used.
- R5: In 64-bit mode (mode code 3) every second byte qualifies, whatever its top bits.
- R6: In real mode (code 0) or virtual-8086 mode (code 1), a qualifying vector prefix is reported with its class and with ud=1. Every other result has ud=0.
- R7: In 64-bit mode, a lead byte 0x40..0x4F gives class REX (code 1), length 1, 1 byte used. The outputs are ext_w=bit3, ext_r=bit2, ext_x=bit1 and ext_b=bit0 of that byte.
- R8: Outside 64-bit mode, lead bytes 0x40..0x4F give class NONE, length 0, 1 byte used, with all extension outputs zero.
- R9: In 64-bit mode, the vector extension outputs are the complements of the stored bits:
  - ext_r is ~byte1[7].
  - ext_x is ~byte1[6] (VEX3 and EVEX). ext_b is ~byte1[5] (VEX3 and EVEX). ext_r_hi is ~byte1[4] (EVEX only).
  - For VEX2, ext_vreg[3:0] is ~byte1[6:3]. For VEX3 and EVEX it is ~byte2[6:3].
  - ext_vreg[4] is ~byte3[3] (EVEX only).
  - ext_w is byte2[7] (VEX3 and EVEX).
  - Every field not listed here is 0.
- R10: Outside 64-bit mode, ext_r, ext_x, ext_b, ext_r_hi and ext_vreg[4:3] are forced to 0 on every result.
- R11: res_done pulses for exactly one cycle, in the cycle after the edge that accepts the last byte. From that cycle until res_ack is sampled high, in_ready is 0 and all result outputs hold steady. res_ack may already be high in the res_done cycle.
- R12: Any other lead byte gives class NONE, length 0, 1 byte used. The mode is sampled when the lead byte is accepted and applies to the whole instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_mode | input | 2 | 0 real, 1 virtual-8086, 2 32-bit, 3 64-bit |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block accepts a byte |
| in_byte | input | 8 | Instruction byte |
| res_ack | input | 1 | Consumer takes the held result |
| res_done | output | 1 | One-cycle result strobe |
| res_type | output | 3 | Class: 0 none, 1 REX, 2 VEX2, 3 VEX3, 4 EVEX |
| res_len | output | 3 | Prefix length in bytes |
| res_used | output | 3 | Bytes taken from the stream |
| res_ud | output | 1 | Invalid-opcode indication |
| ext_w | output | 1 | Operand-width bit |
| ext_r | output | 1 | Reg-field extension |
| ext_x | output | 1 | Index extension |
| ext_b | output | 1 | Base/rm extension |
| ext_r_hi | output | 1 | Second reg extension (EVEX) |
| ext_vreg | output | 5 | Extra source register index, un-inverted |

## Verification
The bench targets these corner cases:

- **Second-byte qualification.** A lead byte followed by a byte with top bits 00, 01 or 10 must give a legacy result outside 64-bit mode and a prefix in 64-bit mode. A design that ignores the mode here either swallows LES/LDS/BOUND or rejects valid 64-bit prefixes.
- **The 0x40..0x4F range in 32-bit mode.** A design that does not gate REX on the mode reports REX for what are ordinary INC/DEC opcodes.
- **Inverted fields.** Patterns of all ones, all zeros and random values catch a missed complement or a field taken from the wrong byte.
- **32-bit forcing.** Random 32-bit and real-mode prefixes catch leaked high register bits.
- **Handshake.** Delayed acknowledges, acknowledges in the done cycle, and input bubbles catch a strobe that lasts too long, a result that drifts, or a byte accepted while stalled.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

    localparam int BYTE_W = 8;
    localparam int VREG_W = 5;
    localparam int LEN_W  = 3;

    localparam logic [BYTE_W-1:0] LEAD_VEX2 = 8'hC5;
    localparam logic [BYTE_W-1:0] LEAD_VEX3 = 8'hC4;
    localparam logic [BYTE_W-1:0] LEAD_EVEX = 8'h62;
    localparam logic [3:0]        REX_NIBBLE = 4'h4;

    typedef enum logic [1:0] {
        MODE_REAL   = 2'd0,
        MODE_V86    = 2'd1,
        MODE_PROT32 = 2'd2,
        MODE_LONG64 = 2'd3
    } cpu_mode_e;

    typedef enum logic [2:0] {
        PFX_NONE = 3'd0,
        PFX_REX  = 3'd1,
        PFX_VEX2 = 3'd2,
        PFX_VEX3 = 3'd3,
        PFX_EVEX = 3'd4
    } pfx_e;

    typedef struct packed {
        logic              w;
        logic              r;
        logic              x;
        logic              b;
        logic              r_hi;
        logic [VREG_W-1:0] vreg;
    } ext_t;

    // True when a byte following a vector lead byte has the register-only form
    function automatic logic reg_form(input logic [BYTE_W-1:0] bt);
        return bt[7:6] == 2'b11;
    endfunction

    function automatic logic is_vector(input pfx_e k);
        return (k == PFX_VEX2) || (k == PFX_VEX3) || (k == PFX_EVEX);
    endfunction

    function automatic logic is_no_vec_mode(input cpu_mode_e m);
        return (m == MODE_REAL) || (m == MODE_V86);
    endfunction

    function automatic logic [LEN_W-1:0] full_len(input pfx_e k);
        case (k)
            PFX_REX:  return 3'd1;
            PFX_VEX2: return 3'd2;
            PFX_VEX3: return 3'd3;
            PFX_EVEX: return 3'd4;
            default:  return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/vpc_lead_classify.sv
module vpc_lead_classify
    import vpc_pkg::*;
(
    input  logic [BYTE_W-1:0] lead,
    input  cpu_mode_e         mode,
    output pfx_e              kind
);
    always_comb begin
        kind = PFX_NONE;
        if (mode == MODE_LONG64 && lead[7:4] == REX_NIBBLE)
            kind = PFX_REX;
        else if (lead == LEAD_VEX2)
            kind = PFX_VEX2;
        else if (lead == LEAD_VEX3)
            kind = PFX_VEX3;
        else if (lead == LEAD_EVEX)
            kind = PFX_EVEX;
    end
endmodule

// File: rtl/vpc_field_decode.sv
module vpc_field_decode
    import vpc_pkg::*;
(
    input  pfx_e              kind,
    input  cpu_mode_e         mode,
    input  logic [BYTE_W-1:0] byte_a,
    input  logic [BYTE_W-1:0] byte_b,
    input  logic [BYTE_W-1:0] byte_c,
    output ext_t              ext
);
    logic unused_bits;
    assign unused_bits = ^{byte_b[2:0], byte_c[7:4], byte_c[2:0]};

    always_comb begin
        ext = '0;
        case (kind)
            PFX_REX: begin
                ext.w = byte_a[3];
                ext.r = byte_a[2];
                ext.x = byte_a[1];
                ext.b = byte_a[0];
            end
            PFX_VEX2: begin
                ext.r         = ~byte_a[7];
                ext.vreg[3:0] = ~byte_a[6:3];
            end
            PFX_VEX3: begin
                ext.r         = ~byte_a[7];
                ext.x         = ~byte_a[6];
                ext.b         = ~byte_a[5];
                ext.w         = byte_b[7];
                ext.vreg[3:0] = ~byte_b[6:3];
            end
            PFX_EVEX: begin
                ext.r         = ~byte_a[7];
                ext.x         = ~byte_a[6];
                ext.b         = ~byte_a[5];
                ext.r_hi      = ~byte_a[4];
                ext.w         = byte_b[7];
                ext.vreg[3:0] = ~byte_b[6:3];
                ext.vreg[4]   = ~byte_c[3];
            end
            default: ;
        endcase
        // Narrow modes reach only the low eight registers
        if (mode != MODE_LONG64) begin
            ext.r         = 1'b0;
            ext.x         = 1'b0;
            ext.b         = 1'b0;
            ext.r_hi      = 1'b0;
            ext.vreg[4:3] = 2'b00;
        end
    end
endmodule

// File: rtl/vpc_top.sv
module vpc_top
    import vpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cpu_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              res_ack,
    output logic              res_done,
    output logic [2:0]        res_type,
    output logic [LEN_W-1:0]  res_len,
    output logic [LEN_W-1:0]  res_used,
    output logic              res_ud,
    output logic              ext_w,
    output logic              ext_r,
    output logic              ext_x,
    output logic              ext_b,
    output logic              ext_r_hi,
    output logic [VREG_W-1:0] ext_vreg
);
    typedef enum logic [2:0] {ST_LEAD, ST_B1, ST_B2, ST_B3, ST_HOLD} state_e;

    state_e            state, next_state;
    pfx_e              kind_q, lead_kind, dec_kind;
    cpu_mode_e         mode_q, dec_mode;
    logic [BYTE_W-1:0] b1_q, b2_q, byte_a, byte_b;
    ext_t              dec_ext, ext_q;
    pfx_e              type_q;
    logic              take, fin;
    pfx_e              fin_type;
    logic [LEN_W-1:0]  fin_used;

    assign in_ready = (state != ST_HOLD);
    assign take     = in_valid && in_ready;

    vpc_lead_classify lead_i (
        .lead (in_byte),
        .mode (cpu_mode_e'(cpu_mode)),
        .kind (lead_kind)
    );

    assign dec_kind = (state == ST_LEAD) ? lead_kind : kind_q;
    assign dec_mode = (state == ST_LEAD) ? cpu_mode_e'(cpu_mode) : mode_q;
    assign byte_a   = (state == ST_LEAD || state == ST_B1) ? in_byte : b1_q;
    assign byte_b   = (state == ST_B2) ? in_byte : b2_q;

    vpc_field_decode dec_i (
        .kind   (dec_kind),
        .mode   (dec_mode),
        .byte_a (byte_a),
        .byte_b (byte_b),
        .byte_c (in_byte),
        .ext    (dec_ext)
    );

    always_comb begin
        next_state = state;
        fin        = 1'b0;
        fin_type   = PFX_NONE;
        fin_used   = '0;
        case (state)
            ST_LEAD: if (take) begin
                if (lead_kind == PFX_REX || lead_kind == PFX_NONE) begin
                    fin = 1'b1; fin_type = lead_kind; fin_used = 3'd1;
                end else begin
                    next_state = ST_B1;
                end
            end
            ST_B1: if (take) begin
                if (mode_q != MODE_LONG64 && !reg_form(in_byte)) begin
                    fin = 1'b1; fin_type = PFX_NONE; fin_used = 3'd2;
                end else if (kind_q == PFX_VEX2) begin
                    fin = 1'b1; fin_type = PFX_VEX2; fin_used = 3'd2;
                end else begin
                    next_state = ST_B2;
                end
            end
            ST_B2: if (take) begin
                if (kind_q == PFX_VEX3) begin
                    fin = 1'b1; fin_type = PFX_VEX3; fin_used = 3'd3;
                end else begin
                    next_state = ST_B3;
                end
            end
            ST_B3: if (take) begin
                fin = 1'b1; fin_type = PFX_EVEX; fin_used = 3'd4;
            end
            ST_HOLD: if (res_ack) next_state = ST_LEAD;
            default: next_state = ST_LEAD;
        endcase
        if (fin) next_state = ST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_LEAD;
            kind_q   <= PFX_NONE;
            mode_q   <= MODE_REAL;
            b1_q     <= '0;
            b2_q     <= '0;
            res_done <= 1'b0;
            type_q   <= PFX_NONE;
            res_len  <= '0;
            res_used <= '0;
            res_ud   <= 1'b0;
            ext_q    <= '0;
        end else begin
            state    <= next_state;
            res_done <= fin;
            if (state == ST_LEAD && take) begin
                kind_q <= lead_kind;
                mode_q <= cpu_mode_e'(cpu_mode);
            end
            if (state == ST_B1 && take) b1_q <= in_byte;
            if (state == ST_B2 && take) b2_q <= in_byte;
            if (fin) begin
                type_q   <= fin_type;
                res_len  <= full_len(fin_type);
                res_used <= fin_used;
                res_ud   <= is_vector(fin_type) && is_no_vec_mode(dec_mode);
                ext_q    <= (fin_type == PFX_NONE) ? '0 : dec_ext;
            end
        end
    end

    assign res_type = type_q;
    assign ext_w    = ext_q.w;
    assign ext_r    = ext_q.r;
    assign ext_x    = ext_q.x;
    assign ext_b    = ext_q.b;
    assign ext_r_hi = ext_q.r_hi;
    assign ext_vreg = ext_q.vreg;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_done |=> !res_done);
    // R11
    done_stall_chk: assert property (@(posedge clk) disable iff (rst)
        res_done |-> !in_ready);
    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !res_ack) |=> ($stable(res_type) && $stable(res_len)
                                     && $stable(res_used) && $stable(ext_q)));
    // R6
    ud_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (res_done && res_ud) |-> (res_type >= 3'd2 && res_type <= 3'd4));
    // R10
    narrow_force_chk: assert property (@(posedge clk) disable iff (rst)
        (res_done && mode_q != MODE_LONG64) |->
            (!ext_r && !ext_x && !ext_b && !ext_r_hi && ext_vreg[4:3] == 2'b00));
    // R7
    rex_len_chk: assert property (@(posedge clk) disable iff (rst)
        (res_done && res_type == 3'd1) |-> (res_len == 3'd1 && mode_q == MODE_LONG64));
    // R12
    used_bound_chk: assert property (@(posedge clk) disable iff (rst)
        res_done |-> (res_len <= res_used && res_used != 3'd0));

endmodule

// File: tb/vpc_top_tb.sv
module vpc_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 60000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cpu_mode = 2'd3;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = 8'h00;
    logic       res_ack = 1'b0;
    logic       res_done;
    logic [2:0] res_type;
    logic [2:0] res_len;
    logic [2:0] res_used;
    logic       res_ud;
    logic       ext_w, ext_r, ext_x, ext_b, ext_r_hi;
    logic [4:0] ext_vreg;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpc_top dut_i (
        .clk(clk), .rst(rst), .cpu_mode(cpu_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .res_ack(res_ack), .res_done(res_done), .res_type(res_type),
        .res_len(res_len), .res_used(res_used), .res_ud(res_ud),
        .ext_w(ext_w), .ext_r(ext_r), .ext_x(ext_x), .ext_b(ext_b),
        .ext_r_hi(ext_r_hi), .ext_vreg(ext_vreg)
    );

    typedef struct packed {
        logic [2:0] typ;
        logic [2:0] len;
        logic [2:0] used;
        logic       ud;
        logic       w, r, x, b, rh;
        logic [4:0] vreg;
    } exp_t;

    function automatic exp_t model(input logic [1:0] m, input logic [7:0] b0,
                                   input logic [7:0] b1, input logic [7:0] b2,
                                   input logic [7:0] b3);
        exp_t e;
        e = '0;
        e.used = 3'd1;
        if (m == 2'd3 && b0 >= 8'h40 && b0 <= 8'h4F) begin
            e.typ = 3'd1; e.len = 3'd1;
            e.w = b0[3]; e.r = b0[2]; e.x = b0[1]; e.b = b0[0];
        end else if (b0 == 8'hC5 || b0 == 8'hC4 || b0 == 8'h62) begin
            e.used = 3'd2;
            if (m == 2'd3 || b1[7:6] == 2'b11) begin
                e.typ  = (b0 == 8'hC5) ? 3'd2 : (b0 == 8'hC4) ? 3'd3 : 3'd4;
                e.len  = e.typ;
                e.used = e.typ;
                e.ud   = (m == 2'd0 || m == 2'd1);
                e.r    = !b1[7];
                if (e.typ == 3'd2) begin
                    e.vreg = {1'b0, ~b1[6:3]};
                end else begin
                    e.x = !b1[6]; e.b = !b1[5]; e.w = b2[7];
                    e.vreg = {1'b0, ~b2[6:3]};
                    if (e.typ == 3'd4) begin
                        e.rh = !b1[4];
                        e.vreg[4] = !b3[3];
                    end
                end
                if (m != 2'd3) begin
                    e.r = 0; e.x = 0; e.b = 0; e.rh = 0; e.vreg[4:3] = 2'b00;
                end
            end
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m, input logic [7:0] b0, input exp_t e);
        if (e.typ == 3'd1) return "R7";
        if (b0 >= 8'h40 && b0 <= 8'h4F) return "R8";
        if (e.typ == 3'd0 && e.used == 3'd2) return "R4";
        if (e.typ == 3'd0) return "R12";
        if (e.ud) return "R6";
        if (m != 2'd3) return "R4";
        if (e.typ == 3'd2) return "R1";
        if (e.typ == 3'd3) return "R2";
        return "R3";
    endfunction

    task automatic run_case(input logic [1:0] m, input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3,
                            input int ack_delay, input bit bubbles);
        exp_t e;
        logic [7:0] bs [4];
        string tg, ftg;
        bit got;
        logic [2:0] held_type;
        e = model(m, b0, b1, b2, b3);
        tg = tag_of(m, b0, e);
        ftg = (e.typ == 3'd1) ? "R7" : (m == 2'd3) ? "R9" : "R10";
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
        got = 0;
        cpu_mode = m;
        for (int i = 0; i < 4 && !got; i++) begin
            if (bubbles && ($urandom % 3 == 0)) begin
                in_valid = 1'b0;
                @(posedge clk); @(negedge clk);
            end
            in_valid = 1'b1;
            in_byte  = bs[i];
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            if (res_done) got = 1;
            if (got != (i + 1 == int'(e.used))) begin
                chk(0, "R11", "done timing", int'(res_done), int'(i + 1 == int'(e.used)));
                if (!got) begin
                    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
                    return;
                end
            end
        end
        if (!got) return;
        chk(res_type == e.typ, tg, "type", res_type, e.typ);
        chk(res_len == e.len, tg, "len", res_len, e.len);
        chk(res_used == e.used, tg, "used", res_used, e.used);
        chk(res_ud == e.ud, (e.ud || m < 2'd2) ? "R6" : tg, "ud", res_ud, e.ud);
        chk({ext_w, ext_r, ext_x, ext_b, ext_r_hi, ext_vreg} ==
            {e.w, e.r, e.x, e.b, e.rh, e.vreg}, ftg, "ext",
            {ext_w, ext_r, ext_x, ext_b, ext_r_hi, ext_vreg},
            {e.w, e.r, e.x, e.b, e.rh, e.vreg});
        chk(!in_ready, "R11", "ready low at done", in_ready, 0);
        held_type = res_type;
        for (int d = 0; d < ack_delay; d++) begin
            in_valid = 1'b1;
            in_byte  = 8'hC4;
            @(posedge clk); @(negedge clk);
            chk(!res_done && !in_ready && res_type == held_type, "R11", "stall",
                {res_done, in_ready, res_type}, {1'b0, 1'b0, held_type});
        end
        in_valid = 1'b0;
        res_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        res_ack = 1'b0;
        chk(in_ready && !res_done, "R11", "released", {in_ready, res_done}, 2'b10);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(in_ready && !res_done && res_type == 3'd0, "R11", "reset state",
            {in_ready, res_done, res_type}, 5'b10000);

        // Directed corners
        run_case(2'd3, 8'hC5, 8'h78, 8'h00, 8'h00, 0, 0);  // R1
        run_case(2'd3, 8'hC5, 8'h05, 8'h00, 8'h00, 0, 0);  // R5 low top bits
        run_case(2'd3, 8'hC4, 8'h3F, 8'hFF, 8'h00, 2, 0);  // R2 R5
        run_case(2'd2, 8'hC4, 8'h3F, 8'hFF, 8'h00, 0, 0);  // R4 legacy
        run_case(2'd2, 8'h62, 8'h80, 8'h00, 8'h00, 0, 0);  // R4 legacy
        run_case(2'd2, 8'hC4, 8'hE0, 8'h80, 8'h00, 1, 0);  // R10
        run_case(2'd3, 8'h62, 8'h00, 8'h80, 8'h00, 0, 0);  // R3 R9 all ones
        run_case(2'd3, 8'h62, 8'hFF, 8'h7F, 8'hFF, 0, 0);  // R9 all zeros
        run_case(2'd2, 8'h62, 8'hC0, 8'h00, 8'h00, 3, 0);  // R10 forcing
        run_case(2'd0, 8'hC5, 8'hF8, 8'h00, 8'h00, 0, 0);  // R6
        run_case(2'd1, 8'h62, 8'hF1, 8'h00, 8'h00, 0, 0);  // R6
        run_case(2'd0, 8'hC5, 8'h00, 8'h00, 8'h00, 0, 0);  // R6 legacy, no ud
        run_case(2'd3, 8'h4B, 8'h00, 8'h00, 8'h00, 0, 0);  // R7
        run_case(2'd3, 8'h44, 8'h00, 8'h00, 8'h00, 1, 0);  // R7
        run_case(2'd2, 8'h4B, 8'h00, 8'h00, 8'h00, 0, 0);  // R8
        run_case(2'd3, 8'h90, 8'h00, 8'h00, 8'h00, 0, 0);  // R12
        run_case(2'd3, 8'h3F, 8'h00, 8'h00, 8'h00, 0, 0);  // R12

        // Constrained random
        for (int k = 0; k < 400; k++) begin
            logic [7:0] lb;
            int sel;
            sel = $urandom % 6;
            lb = (sel == 0) ? 8'hC5 : (sel == 1) ? 8'hC4 : (sel == 2) ? 8'h62 :
                 (sel == 3) ? (8'h40 | 8'($urandom % 16)) : 8'($urandom);
            run_case(2'($urandom), lb, 8'($urandom), 8'($urandom), 8'($urandom),
                     $urandom % 3, 1);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule